// File: doc/BRIEF.md
# Indexed Two-Bank CMOS Register Port

This block is the byte-wide I/O-port front end of a battery-backed clock and configuration RAM. Four consecutive port addresses form two index/data pairs. Software first writes an index through the index port of a pair, then reads or writes the data port of that pair. The lower pair reaches a 128-byte window: the clock core's time registers, four control registers and general RAM. The upper pair reaches a separate 128-byte RAM bank, so byte address N in the range 128 to 255 is reached by writing N-128 to the upper index port.

The block holds the index latches, both RAM banks and the control registers. Control register A keeps its low seven bits, and bit 7 reports the core's update-in-progress input. Control register B is a plain byte. Control register C collects the three event flags and clears them when it is read. Control register D reports valid RAM and time. The ten time registers live in the timekeeping core. The block forwards each access to them as a one-cycle strobe that carries the index and the write data, and it returns the core's read data. Integrity checksums over the RAM are left to software.

Port offsets decode as follows: 0 is the lower index, 1 is the lower data, 2 is the upper index and 3 is the upper data. A cycle with `io_rd` high and `io_wr` low is a read. A cycle with `io_wr` high is a write, and a write takes precedence when both are high. Read data is combinational within the read cycle. The effects of a write and of a read take hold at the rising clock edge that ends the cycle.

Top module: `cmos_port_bridge`

## Requirements
- R1: Writing offset 0 (or offset 2) latches bits 6:0 of the write data as the lower (or upper) index, and bit 7 is discarded. Each index holds its value until its own index port is written again. A read of offset 0 or 2 returns the latched index with bit 7 zero, and `io_rdata` is 0 in every cycle that is not a read.
- R2: With a lower index from 14 to 127, a write to offset 1 stores the byte and a later read of offset 1 at that index returns it. This range includes index 0x32.
- R3: Offset 3 reads and writes a 128-byte bank addressed by the upper index. The upper bank is separate from the lower bank at the same index, and an access to it raises neither strobe.
- R4: With a lower index from 0 to 9, a read of offset 1 returns `core_rdata`. A write of offset 1 raises `reg_wr_stb` for that cycle, with `reg_idx` equal to the index and `reg_wdata` equal to the written byte.
- R5: Index 10 (register A) stores bits 6:0 of a write. A read returns those bits together with `core_uip` in bit 7, and a write never changes bit 7.
- R6: Index 11 (register B) is a read/write byte. Its bits 6, 5 and 4 enable the periodic, alarm and update flags into the summary bit of register C.
- R7: Index 12 (register C) returns bit 6 periodic, bit 5 alarm, bit 4 update, bit 7 = OR of each flag ANDed with its enable bit in register B, and bits 3:0 zero. An event pulse sets its flag. A read of register C clears all flags at the end of that cycle, but an event that arrives in the cycle of the read stays set.
- R8: Writes to index 12 and index 13 change nothing. Register D (index 13) always reads 0x80.
- R9: `reg_rd_stb` is high exactly in a read cycle of offset 1 with a lower index from 0 to 13. `reg_wr_stb` is high exactly in a write cycle of offset 1 with a lower index from 0 to 11. The two strobes are never high together, and `reg_idx` and `reg_wdata` are 0 while their strobes are low.
- R10: After reset both indices, the low bits of register A, register B and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 2 | Port offset: 0 lower index, 1 lower data, 2 upper index, 3 upper data |
| io_rd | input | 1 | Read cycle |
| io_wr | input | 1 | Write cycle (wins over io_rd) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 outside a read |
| core_rdata | input | 8 | Time register value from the clock core |
| core_uip | input | 1 | Update-in-progress status from the clock core |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-finished event pulse |
| reg_rd_stb | output | 1 | One-cycle read strobe to the clock core |
| reg_wr_stb | output | 1 | One-cycle write strobe to the clock core |
| reg_idx | output | 4 | Register index that goes with a strobe |
| reg_wdata | output | 8 | Write data that goes with the write strobe |

## Verification
On every cycle the assertions check that the two strobes are never high together and never fire for the upper data port. They also check that the lower index stays put unless offset 0 is written, that register D and the update-in-progress bit read correctly, and that a quiet read of register C leaves every flag cleared. Whether a byte written into either RAM bank comes back intact, whether the banks stay apart at the same index, and whether an event that coincides with a clearing read survives can only be shown by the bench's access sequences. The bench compares these against its reference model cycle by cycle.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;

   localparam int REG_IDX_W      = 4;
   localparam int NUM_TIME_REGS  = 10;
   localparam int FIRST_RAM_IDX  = 14;

   localparam logic [REG_IDX_W-1:0] IDX_CTRL_A = 4'd10;
   localparam logic [REG_IDX_W-1:0] IDX_CTRL_B = 4'd11;
   localparam logic [REG_IDX_W-1:0] IDX_FLAGS  = 4'd12;
   localparam logic [REG_IDX_W-1:0] IDX_STATUS = 4'd13;

   typedef enum logic [1:0] {
      PORT_LO_IDX = 2'd0,
      PORT_LO_DAT = 2'd1,
      PORT_UP_IDX = 2'd2,
      PORT_UP_DAT = 2'd3
   } port_sel_e;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } evt_t;

endpackage

// File: rtl/cmos_index_latch.sv
module cmos_index_latch #(
   parameter int IDX_W     = 7,
   parameter int NUM_PAIRS = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PAIRS-1:0]            wr_en,
   input  logic [IDX_W-1:0]                wdata,
   output logic [NUM_PAIRS-1:0][IDX_W-1:0] idx
);

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            idx[p] <= '0;
         end else if (wr_en[p]) begin
            idx[p] <= wdata;
         end
      end
   end

endmodule

// File: rtl/cmos_ram_bank.sv
module cmos_ram_bank #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/cmos_ctrl_regs.sv
module cmos_ctrl_regs
   import cmos_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_IDX_W-1:0] idx,
   input  logic                 acc_wr,
   input  logic                 acc_rd,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 uip,
   input  evt_t                 evt,
   output logic [DATA_W-1:0]    rdata,
   output logic [2:0]           flags_o
);

   logic [DATA_W-2:0] a_q;
   logic [DATA_W-1:0] b_q;
   evt_t              flags_q;
   evt_t              flags_d;
   logic              summary;
   logic              clr;

   assign clr     = acc_rd && (idx == IDX_FLAGS);
   assign flags_d = (clr ? evt_t'('0) : flags_q) | evt;
   assign summary = |(flags_q & b_q[6:4]);
   assign flags_o = flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         flags_q <= '0;
      end else begin
         flags_q <= flags_d;
         if (acc_wr && idx == IDX_CTRL_A) begin
            a_q <= wdata[DATA_W-2:0];
         end
         if (acc_wr && idx == IDX_CTRL_B) begin
            b_q <= wdata;
         end
      end
   end

   always_comb begin
      unique case (idx)
         IDX_CTRL_A: rdata = {uip, a_q};
         IDX_CTRL_B: rdata = b_q;
         IDX_FLAGS:  rdata = {summary, flags_q, {(DATA_W-4){1'b0}}};
         IDX_STATUS: rdata = {1'b1, {(DATA_W-1){1'b0}}};
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/cmos_port_bridge.sv
module cmos_port_bridge
   import cmos_port_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BANK_DEPTH = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           io_addr,
   input  logic                 io_rd,
   input  logic                 io_wr,
   input  logic [DATA_W-1:0]    io_wdata,
   output logic [DATA_W-1:0]    io_rdata,
   input  logic [DATA_W-1:0]    core_rdata,
   input  logic                 core_uip,
   input  logic                 evt_periodic,
   input  logic                 evt_alarm,
   input  logic                 evt_update,
   output logic                 reg_rd_stb,
   output logic                 reg_wr_stb,
   output logic [REG_IDX_W-1:0] reg_idx,
   output logic [DATA_W-1:0]    reg_wdata
);

   localparam int IDX_W     = $clog2(BANK_DEPTH);
   localparam int NUM_PAIRS = 2;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("cmos_port_bridge: register layout needs DATA_W of 8");
   end
   if (BANK_DEPTH < 16 || (2 ** IDX_W) != BANK_DEPTH) begin : g_bad_depth
      $error("cmos_port_bridge: BANK_DEPTH must be a power of two of at least 16");
   end
   if (IDX_W >= DATA_W) begin : g_bad_idx_w
      $error("cmos_port_bridge: index must be narrower than a data byte");
   end

   port_sel_e                           sel;
   logic                                rd_cyc;
   logic [NUM_PAIRS-1:0]                idx_we;
   logic [NUM_PAIRS-1:0][IDX_W-1:0]     pair_idx;
   logic [NUM_PAIRS-1:0]                bank_we;
   logic [NUM_PAIRS-1:0][DATA_W-1:0]    bank_rdata;
   logic [IDX_W-1:0]                    lo_idx;
   logic                                lo_dat_wr;
   logic                                lo_dat_rd;
   logic                                lo_is_time;
   logic                                lo_is_ctrl;
   logic                                lo_is_ram;
   logic                                lo_core_wr;
   logic [DATA_W-1:0]                   ctrl_rdata;
   logic [2:0]                          flags;
   evt_t                                evt;

   assign sel    = port_sel_e'(io_addr);
   assign rd_cyc = io_rd && !io_wr;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_idx_we
      assign idx_we[p] = io_wr && (io_addr == 2'(2 * p));
   end

   cmos_index_latch #(
      .IDX_W     (IDX_W),
      .NUM_PAIRS (NUM_PAIRS)
   ) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (idx_we),
      .wdata (io_wdata[IDX_W-1:0]),
      .idx   (pair_idx)
   );

   assign lo_idx     = pair_idx[0];
   assign lo_dat_wr  = io_wr && (sel == PORT_LO_DAT);
   assign lo_dat_rd  = rd_cyc && (sel == PORT_LO_DAT);
   assign lo_is_time = lo_idx < IDX_W'(NUM_TIME_REGS);
   assign lo_is_ctrl = !lo_is_time && (lo_idx < IDX_W'(FIRST_RAM_IDX));
   assign lo_is_ram  = !lo_is_time && !lo_is_ctrl;

   for (genvar b = 0; b < NUM_PAIRS; b++) begin : g_bank
      if (b == 0) begin : g_lower
         assign bank_we[b] = lo_dat_wr && lo_is_ram;
      end else begin : g_upper
         assign bank_we[b] = io_wr && (io_addr == 2'(2 * b + 1));
      end

      cmos_ram_bank #(
         .DATA_W (DATA_W),
         .DEPTH  (BANK_DEPTH)
      ) u_bank (
         .clk   (clk),
         .we    (bank_we[b]),
         .addr  (pair_idx[b]),
         .wdata (io_wdata),
         .rdata (bank_rdata[b])
      );
   end

   assign evt = '{per: evt_periodic, alm: evt_alarm, upd: evt_update};

   cmos_ctrl_regs #(
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (lo_idx[REG_IDX_W-1:0]),
      .acc_wr  (lo_dat_wr && lo_is_ctrl),
      .acc_rd  (lo_dat_rd && lo_is_ctrl),
      .wdata   (io_wdata),
      .uip     (core_uip),
      .evt     (evt),
      .rdata   (ctrl_rdata),
      .flags_o (flags)
   );

   assign lo_core_wr = lo_is_time ||
                       (lo_idx == IDX_W'(IDX_CTRL_A)) ||
                       (lo_idx == IDX_W'(IDX_CTRL_B));

   assign reg_rd_stb = lo_dat_rd && !lo_is_ram;
   assign reg_wr_stb = lo_dat_wr && lo_core_wr;
   assign reg_idx    = (reg_rd_stb || reg_wr_stb) ? lo_idx[REG_IDX_W-1:0] : '0;
   assign reg_wdata  = reg_wr_stb ? io_wdata : '0;

   always_comb begin
      io_rdata = '0;
      if (rd_cyc) begin
         unique case (sel)
            PORT_LO_IDX: io_rdata = DATA_W'(pair_idx[0]);
            PORT_UP_IDX: io_rdata = DATA_W'(pair_idx[1]);
            PORT_UP_DAT: io_rdata = bank_rdata[1];
            PORT_LO_DAT: begin
               if (lo_is_time) begin
                  io_rdata = core_rdata;
               end else if (lo_is_ctrl) begin
                  io_rdata = ctrl_rdata;
               end else begin
                  io_rdata = bank_rdata[0];
               end
            end
            default: io_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/cmos_port_bridge_chk.sv
module cmos_port_bridge_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_rdata,
   input logic              core_uip,
   input logic              evt_periodic,
   input logic              evt_alarm,
   input logic              evt_update,
   input logic              reg_rd_stb,
   input logic              reg_wr_stb,
   input logic [IDX_W-1:0]  lo_idx,
   input logic [2:0]        flags
);

   logic rd_lo;
   logic any_evt;
   assign rd_lo   = io_rd && !io_wr && (io_addr == 2'd1);
   assign any_evt = evt_periodic || evt_alarm || evt_update;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd_stb && reg_wr_stb));                                        // R9

   AST_RD_STB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_stb |-> rd_lo);                                               // R9

   AST_UPPER_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == 2'd3) |-> (!reg_rd_stb && !reg_wr_stb));                // R3

   AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == 2'd0) |=> $stable(lo_idx));                    // R1

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == '0));                                        // R1

   AST_UIP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && lo_idx == IDX_W'(10)) |-> (io_rdata[DATA_W-1] == core_uip)); // R5

   AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && lo_idx == IDX_W'(13)) |-> (io_rdata == 8'h80));            // R8

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && lo_idx == IDX_W'(12) && !any_evt) |=> (flags == 3'b000));  // R7

endmodule

bind cmos_port_bridge cmos_port_bridge_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .io_addr      (io_addr),
   .io_rd        (io_rd),
   .io_wr        (io_wr),
   .io_rdata     (io_rdata),
   .core_uip     (core_uip),
   .evt_periodic (evt_periodic),
   .evt_alarm    (evt_alarm),
   .evt_update   (evt_update),
   .reg_rd_stb   (reg_rd_stb),
   .reg_wr_stb   (reg_wr_stb),
   .lo_idx       (lo_idx),
   .flags        (flags)
);

// File: tb/cmos_port_bridge_tb.sv
module cmos_port_bridge_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] io_addr = '0;
   logic       io_rd = 1'b0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [7:0] core_rdata = '0;
   logic       core_uip = 1'b0;
   logic       evt_periodic = 1'b0;
   logic       evt_alarm = 1'b0;
   logic       evt_update = 1'b0;
   logic       reg_rd_stb;
   logic       reg_wr_stb;
   logic [3:0] reg_idx;
   logic [7:0] reg_wdata;

   int checks = 0;
   int fails  = 0;

   // reference model state
   int         m_lo_idx = 0;
   int         m_up_idx = 0;
   logic [7:0] m_lo [128];
   logic [7:0] m_up [128];
   bit         k_lo [128];
   bit         k_up [128];
   logic [6:0] m_a = '0;
   logic [7:0] m_b = '0;
   logic [2:0] m_fl = '0;   // [2] periodic, [1] alarm, [0] update

   always #2 clk = ~clk;

   cmos_port_bridge u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .io_addr      (io_addr),
      .io_rd        (io_rd),
      .io_wr        (io_wr),
      .io_wdata     (io_wdata),
      .io_rdata     (io_rdata),
      .core_rdata   (core_rdata),
      .core_uip     (core_uip),
      .evt_periodic (evt_periodic),
      .evt_alarm    (evt_alarm),
      .evt_update   (evt_update),
      .reg_rd_stb   (reg_rd_stb),
      .reg_wr_stb   (reg_wr_stb),
      .reg_idx      (reg_idx),
      .reg_wdata    (reg_wdata)
   );

   task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   // One bus cycle: drive at negedge, compare with the model, then let the model advance.
   task automatic cyc(input logic [1:0] a, input logic rd, input logic wr,
                      input logic [7:0] d, input logic [2:0] ev, input string req);
      bit         do_rd;
      bit         known;
      bit         e_rs;
      bit         e_ws;
      logic [7:0] e;
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
      {evt_periodic, evt_alarm, evt_update} = ev;
      #1;
      do_rd = rd && !wr;
      e_rs  = do_rd && a == 2'd1 && m_lo_idx < 14;
      e_ws  = wr && a == 2'd1 && m_lo_idx < 12;
      check("R9 rd strobe", {7'b0, reg_rd_stb}, {7'b0, e_rs});
      check("R9 wr strobe", {7'b0, reg_wr_stb}, {7'b0, e_ws});
      check("R9/R4 reg_idx", {4'b0, reg_idx}, (e_rs || e_ws) ? 8'(m_lo_idx) : 8'h00);
      check("R9/R4 reg_wdata", reg_wdata, e_ws ? d : 8'h00);
      known = 1'b1;
      e = 8'h00;
      if (do_rd) begin
         case (a)
            2'd0: e = 8'(m_lo_idx);
            2'd2: e = 8'(m_up_idx);
            2'd3: begin e = m_up[m_up_idx]; known = k_up[m_up_idx]; end
            default: begin
               if (m_lo_idx < 10)       e = core_rdata;
               else if (m_lo_idx == 10) e = {core_uip, m_a};
               else if (m_lo_idx == 11) e = m_b;
               else if (m_lo_idx == 12) e = {|(m_fl & m_b[6:4]), m_fl, 4'b0};
               else if (m_lo_idx == 13) e = 8'h80;
               else begin e = m_lo[m_lo_idx]; known = k_lo[m_lo_idx]; end
            end
         endcase
      end
      if (known) check(req, io_rdata, e);
      @(posedge clk);
      if (do_rd && a == 2'd1 && m_lo_idx == 12) m_fl = ev;
      else m_fl = m_fl | ev;
      if (wr) begin
         case (a)
            2'd0: m_lo_idx = int'(d[6:0]);
            2'd2: m_up_idx = int'(d[6:0]);
            2'd3: begin m_up[m_up_idx] = d; k_up[m_up_idx] = 1'b1; end
            default: begin
               if (m_lo_idx == 10)      m_a = d[6:0];
               else if (m_lo_idx == 11) m_b = d;
               else if (m_lo_idx >= 14) begin m_lo[m_lo_idx] = d; k_lo[m_lo_idx] = 1'b1; end
            end
         endcase
      end
   endtask

   task automatic idle(input logic [2:0] ev);
      cyc(2'd0, 1'b0, 1'b0, 8'h00, ev, "R1 idle");
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin
         k_lo[i] = 1'b0; k_up[i] = 1'b0; m_lo[i] = '0; m_up[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      cyc(2'd0, 1'b1, 1'b0, 8'h00, 3'b000, "R10 lower index");
      cyc(2'd2, 1'b1, 1'b0, 8'h00, 3'b000, "R10 upper index");
      cyc(2'd0, 1'b0, 1'b1, 8'd10, 3'b000, "R1");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R10 reg A");
      cyc(2'd0, 1'b0, 1'b1, 8'd11, 3'b000, "R1");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R10 reg B");
      cyc(2'd0, 1'b0, 1'b1, 8'd12, 3'b000, "R1");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R10 reg C");

      // R1 index latching, bit 7 dropped, held values
      cyc(2'd0, 1'b0, 1'b1, 8'hC5, 3'b000, "R1");
      cyc(2'd2, 1'b0, 1'b1, 8'h92, 3'b000, "R1");
      cyc(2'd0, 1'b1, 1'b0, 8'h00, 3'b000, "R1 lower index");
      cyc(2'd2, 1'b1, 1'b0, 8'h00, 3'b000, "R1 upper index");
      idle(3'b000);

      // R2 / R3 RAM banks, same index in both
      for (int n = 0; n < 6; n++) begin
         logic [7:0] ix;
         case (n)
            0: ix = 8'd14;
            1: ix = 8'h32;
            2: ix = 8'd127;
            3: ix = 8'd20;
            4: ix = 8'd64;
            default: ix = 8'd99;
         endcase
         cyc(2'd0, 1'b0, 1'b1, ix, 3'b000, "R1");
         cyc(2'd2, 1'b0, 1'b1, ix, 3'b000, "R1");
         cyc(2'd1, 1'b0, 1'b1, 8'hA0 ^ ix, 3'b000, "R2 write");
         cyc(2'd3, 1'b0, 1'b1, 8'h5F ^ ix, 3'b000, "R3 write");
      end
      for (int n = 0; n < 6; n++) begin
         logic [7:0] ix;
         case (n)
            0: ix = 8'd14;
            1: ix = 8'h32;
            2: ix = 8'd127;
            3: ix = 8'd20;
            4: ix = 8'd64;
            default: ix = 8'd99;
         endcase
         cyc(2'd0, 1'b0, 1'b1, ix, 3'b000, "R1");
         cyc(2'd2, 1'b0, 1'b1, ix, 3'b000, "R1");
         cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R2 read back");
         cyc(2'd3, 1'b1, 1'b0, 8'h00, 3'b000, "R3 read back");
      end
      // R3 upper bank write leaves lower index and lower bank alone
      cyc(2'd3, 1'b0, 1'b1, 8'h3C, 3'b000, "R3 write");
      cyc(2'd0, 1'b1, 1'b0, 8'h00, 3'b000, "R1 lower index held");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R3 lower untouched");

      // R4 time registers through the core interface
      for (int t = 0; t < 10; t += 3) begin
         core_rdata = 8'h11 * 8'(t + 1);
         cyc(2'd0, 1'b0, 1'b1, 8'(t), 3'b000, "R1");
         cyc(2'd1, 1'b0, 1'b1, 8'h40 + 8'(t), 3'b000, "R4 write");
         cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R4 read");
      end
      core_rdata = 8'hE7;
      cyc(2'd0, 1'b0, 1'b1, 8'd9, 3'b000, "R1");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R4 read year");

      // R5 register A
      cyc(2'd0, 1'b0, 1'b1, 8'd10, 3'b000, "R1");
      cyc(2'd1, 1'b0, 1'b1, 8'hFF, 3'b000, "R5 write");
      core_uip = 1'b0;
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R5 uip low");
      core_uip = 1'b1;
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R5 uip high");
      cyc(2'd1, 1'b0, 1'b1, 8'h26, 3'b000, "R5 write");
      core_uip = 1'b0;
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R5 bit7 not stored");

      // R6 register B: enable periodic only
      cyc(2'd0, 1'b0, 1'b1, 8'd11, 3'b000, "R1");
      cyc(2'd1, 1'b0, 1'b1, 8'h4B, 3'b000, "R6 write");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R6 read");

      // R7 flag register
      cyc(2'd0, 1'b0, 1'b1, 8'd12, 3'b000, "R1");
      idle(3'b100);
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R7 periodic enabled");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R7 cleared by read");
      idle(3'b010);
      idle(3'b001);
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b100, "R7 disabled flags");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R7 event during read kept");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R7 now clear");

      // R8 register C and D ignore writes
      idle(3'b010);
      cyc(2'd1, 1'b0, 1'b1, 8'h00, 3'b000, "R8 write C");
      cyc(2'd1, 1'b0, 1'b1, 8'hFF, 3'b000, "R8 write C");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R8 C unchanged");
      cyc(2'd0, 1'b0, 1'b1, 8'd13, 3'b000, "R1");
      cyc(2'd1, 1'b0, 1'b1, 8'h00, 3'b000, "R8 write D");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R8 D reads valid");
      cyc(2'd0, 1'b0, 1'b1, 8'd11, 3'b000, "R1");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R8 B unchanged");

      // R9 write wins when both strobes asked for
      cyc(2'd1, 1'b1, 1'b1, 8'h70, 3'b000, "R9 write priority");
      cyc(2'd1, 1'b1, 1'b0, 8'h00, 3'b000, "R6 read after write");
      cyc(2'd2, 1'b1, 1'b0, 8'h00, 3'b000, "R1 upper index held");
      idle(3'b000);

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

endmodule